// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block keeps a DRAM's contents alive by pacing auto-refresh commands so that 4096 of them fall inside every 64 ms retention window. A free-running interval timer fires once per refresh slot, which is one 4096th of the window expressed in clock cycles. Each firing adds one unit to a small refresh debt. While debt is outstanding the block raises a request to the command sequencer. Once the debt reaches its ceiling the request is also flagged urgent, and the sequencer must grant it rather than finish its current burst.

On a grant the scheduler owns the command bus. If any bank still has an open row, it first issues a precharge of all banks and waits out the precharge time. It then issues the auto-refresh command and holds a lockout for the refresh cycle time, during which the sequencer must not issue an activate or another refresh. The memory supplies the row address for the refresh, so no address is driven. When self-refresh is requested, the same refresh encoding goes out with clock-enable low. Clock-enable stays low until the request drops, and the refresh cycle time is then observed again before the block returns to idle.

The request/grant pair follows valid/ready rules. A request raised by debt stays high until a grant is sampled with it. A grant sampled while the request is low does nothing. The sequencer may hold back the grant for as long as the request is not urgent.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset the request, urgent flag, command-valid and lockout are low, clock-enable is high and the command lines show deselect (code {cs_n,ras_n,cas_n,we_n} = 4'b1111).
- R2: The first refresh-slot tick comes REFI_CYC clock edges after reset is released, and later ticks follow every REFI_CYC edges. Each tick adds one to the debt, and the request is high whenever the block is idle with non-zero debt.
- R3: A debt-driven request stays high until it is granted. A grant sampled while the request is low produces no command and no lockout.
- R4: With no bank open, a grant produces an auto-refresh command (code 4'b0001, clock-enable high) in the cycle after the grant edge.
- R5: With any bank open, a grant first produces precharge-all (code 4'b0010 with A10 high), and the auto-refresh follows exactly RP_CYC cycles later.
- R6: Lockout is high from the cycle after the grant until RFC_CYC cycles after the refresh command. No two refresh commands are closer than RFC_CYC cycles.
- R7: Each auto-refresh removes one unit of debt. The request stays high after the lockout ends until every owed refresh has been issued.
- R8: The urgent flag is high when the debt equals DEBT_MAX. Further ticks leave the debt at DEBT_MAX.
- R9: A grant while self-refresh is requested sends the refresh code with clock-enable low (a self-request with zero debt also raises the request). Clock-enable stays low with no further commands while the self-request stays high. Clock-enable rises one cycle after the self-request drops, and lockout then holds for RFC_CYC cycles.
- R10: Self-refresh clears the debt and holds the interval timer at its reload value. The next tick comes REFI_CYC edges after the edge on which clock-enable was raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_open_i | input | NUM_BANKS | One bit per bank with an open row |
| self_ref_i | input | 1 | Asks for self-refresh entry; level held for its duration |
| ref_gnt_i | input | 1 | Grant from the command sequencer (ready) |
| ref_req_o | output | 1 | Refresh request (valid) |
| ref_urgent_o | output | 1 | Debt at its ceiling; grant must not be delayed |
| lockout_o | output | 1 | Sequencer must not drive commands |
| cmd_vld_o | output | 1 | A command is on the lines this cycle |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_a10_o | output | 1 | Precharge-all select bit |
| cmd_cke_o | output | 1 | Clock enable |

## Verification
A debt count that is off by one would show at the ports within one refresh slot. The request would drop one refresh too early or stay high one refresh too long after a drain, and the urgent flag would rise one slot early or late. A wrong lockout or precharge counter shifts the refresh command or the lockout edge by whole cycles, so the bench checks those edges to the exact cycle. A timer that fails to hold during self-refresh moves the first request after exit away from exactly one interval.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RP_WAIT,
    ST_RFC_WAIT,
    ST_SELF
  } rfsh_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam dram_cmd_t CMD_PREA  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam dram_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int REFI_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= RELOAD;
    else if (hold_i)           cnt_q <= RELOAD;
    else if (cnt_q == '0)      cnt_q <= RELOAD;
    else                       cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = !hold_i && (cnt_q == '0);

  generate
    if (REFI_CYC > 1) begin : g_tick_chk
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic pending_o,
  output logic full_o
);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] LIMIT = DW'(DEBT_MAX);

  logic [DW-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) debt_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (debt_q != LIMIT) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0)    debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign pending_o = (debt_q != '0);
  assign full_o    = (debt_q == LIMIT);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> pending_o);
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int RP_CYC  = 3,
  parameter int RFC_CYC = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pending_i,
  input  logic      any_open_i,
  input  logic      self_ref_i,
  input  logic      gnt_i,
  output logic      req_o,
  output logic      lockout_o,
  output logic      dec_o,
  output logic      in_self_o,
  output logic      vld_o,
  output dram_cmd_t cmd_o,
  output logic      cke_o
);
  localparam int MAXW = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int CW   = $clog2(MAXW + 1);

  rfsh_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          self_q;
  logic          accept, go_ref, ref_self;

  assign req_o     = (state_q == ST_IDLE) && (pending_i || self_ref_i);
  assign accept    = req_o && gnt_i;
  assign go_ref    = (accept && !any_open_i) || (state_q == ST_RP_WAIT && cnt_q == '0);
  assign ref_self  = (state_q == ST_IDLE) ? self_ref_i : self_q;
  assign dec_o     = go_ref && !ref_self;
  assign in_self_o = (state_q == ST_SELF);
  assign lockout_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      self_q  <= 1'b0;
      vld_o   <= 1'b0;
      cmd_o   <= CMD_DESEL;
      cke_o   <= 1'b1;
    end else begin
      vld_o <= 1'b0;
      cmd_o <= CMD_DESEL;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          self_q <= self_ref_i;
          if (any_open_i) begin
            vld_o   <= 1'b1;
            cmd_o   <= CMD_PREA;
            state_q <= ST_RP_WAIT;
            cnt_q   <= CW'(RP_CYC - 1);
          end
        end
        ST_RP_WAIT:  if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        ST_RFC_WAIT: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                     else state_q <= ST_IDLE;
        ST_SELF: if (!self_ref_i) begin
          cke_o   <= 1'b1;
          state_q <= ST_RFC_WAIT;
          cnt_q   <= CW'(RFC_CYC - 1);
        end
        default: state_q <= ST_IDLE;
      endcase
      if (go_ref) begin
        vld_o <= 1'b1;
        cmd_o <= CMD_AREF;
        if (ref_self) begin
          cke_o   <= 1'b0;
          state_q <= ST_SELF;
        end else begin
          state_q <= ST_RFC_WAIT;
          cnt_q   <= CW'(RFC_CYC - 1);
        end
      end
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i && pending_i) |=> req_o);
  // R9
  cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (lockout_o && !req_o));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REFI_CYC  = 1950,
  parameter int RP_CYC    = 3,
  parameter int RFC_CYC   = 10,
  parameter int DEBT_MAX  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] banks_open_i,
  input  logic                 self_ref_i,
  input  logic                 ref_gnt_i,
  output logic                 ref_req_o,
  output logic                 ref_urgent_o,
  output logic                 lockout_o,
  output logic                 cmd_vld_o,
  output logic                 cmd_cs_n_o,
  output logic                 cmd_ras_n_o,
  output logic                 cmd_cas_n_o,
  output logic                 cmd_we_n_o,
  output logic                 cmd_a10_o,
  output logic                 cmd_cke_o
);
  logic      tick, pending, full, dec, in_self;
  dram_cmd_t cmd;

  refi_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_i(in_self), .tick_o(tick)
  );

  refresh_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst_n(rst_n), .inc_i(tick), .dec_i(dec), .clr_i(in_self),
    .pending_o(pending), .full_o(full)
  );

  refresh_seq #(.RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .any_open_i(|banks_open_i),
    .self_ref_i(self_ref_i), .gnt_i(ref_gnt_i), .req_o(ref_req_o),
    .lockout_o(lockout_o), .dec_o(dec), .in_self_o(in_self),
    .vld_o(cmd_vld_o), .cmd_o(cmd), .cke_o(cmd_cke_o)
  );

  assign ref_urgent_o = full;
  assign cmd_cs_n_o   = cmd.cs_n;
  assign cmd_ras_n_o  = cmd.ras_n;
  assign cmd_cas_n_o  = cmd.cas_n;
  assign cmd_we_n_o   = cmd.we_n;
  assign cmd_a10_o    = cmd.a10;

  localparam int GW = $clog2(RFC_CYC + 1);
  logic [GW-1:0] gap_q;
  logic          aref_seen;
  assign aref_seen = cmd_vld_o && !cmd_cs_n_o && !cmd_ras_n_o && !cmd_cas_n_o && cmd_we_n_o;

  always_ff @(posedge clk) begin
    if (!rst_n)                      gap_q <= GW'(RFC_CYC);
    else if (aref_seen)              gap_q <= GW'(1);
    else if (gap_q != GW'(RFC_CYC))  gap_q <= gap_q + 1'b1;
  end

  // R6
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aref_seen |-> (gap_q == GW'(RFC_CYC)));
  // R6
  cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> lockout_o);
  // R8
  urgent_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent_o |-> (ref_req_o || lockout_o));
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int NB    = 4;
  localparam int REFI  = 100;
  localparam int TRP   = 2;
  localparam int TRFC  = 5;
  localparam int DMAX  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] banks_open = '0;
  logic self_ref = 1'b0;
  logic gnt = 1'b0;
  logic req, urgent, lockout, vld, cs_n, ras_n, cas_n, we_n, a10, cke;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dram_refresh_sched #(.NUM_BANKS(NB), .REFI_CYC(REFI), .RP_CYC(TRP),
                       .RFC_CYC(TRFC), .DEBT_MAX(DMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .banks_open_i(banks_open), .self_ref_i(self_ref),
    .ref_gnt_i(gnt), .ref_req_o(req), .ref_urgent_o(urgent), .lockout_o(lockout),
    .cmd_vld_o(vld), .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n),
    .cmd_we_n_o(we_n), .cmd_a10_o(a10), .cmd_cke_o(cke)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; gnt = 1'b0; self_ref = 1'b0; banks_open = '0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic grant();
    gnt = 1'b1;
    step();
    gnt = 1'b0;
  endtask

  initial begin
    int miss;
    int nref;

    // ---- R1, R2, R3, R4, R6, R7
    do_reset();
    chk("R1 req", req, 0);
    chk("R1 urgent", urgent, 0);
    chk("R1 vld", vld, 0);
    chk("R1 lockout", lockout, 0);
    chk("R1 cke", cke, 1);
    chk("R1 code", code(), 15);
    repeat (9) step();
    gnt = 1'b1; step(); gnt = 1'b0;
    chk("R3 stray grant vld", vld, 0);
    chk("R3 stray grant lockout", lockout, 0);
    repeat (REFI - 1 - 10) step();
    chk("R2 before first tick", req, 0);
    step();
    chk("R2 first tick", req, 1);
    miss = 0;
    for (int i = 0; i < 30; i++) begin step(); if (!req) miss++; end
    chk("R3 request held", miss, 0);
    grant();
    chk("R4 vld", vld, 1);
    chk("R4 refresh code", code(), 1);
    chk("R4 cke", cke, 1);
    chk("R6 lockout on", lockout, 1);
    miss = 0;
    for (int i = 0; i < TRFC - 1; i++) begin step(); if (!lockout || vld) miss++; end
    chk("R6 lockout held", miss, 0);
    step();
    chk("R6 lockout off", lockout, 0);
    chk("R7 debt drained", req, 0);

    // ---- R5
    do_reset();
    while (!req) step();
    banks_open = 4'b0100;
    grant();
    chk("R5 precharge code", code(), 2);
    chk("R5 a10", a10, 1);
    chk("R5 vld", vld, 1);
    banks_open = '0;
    miss = 0;
    for (int i = 0; i < TRP - 1; i++) begin step(); if (vld) miss++; end
    chk("R5 quiet during rp", miss, 0);
    step();
    chk("R5 refresh after rp", vld ? code() : -1, 1);
    repeat (TRFC) step();
    chk("R6 lockout off after prea", lockout, 0);

    // ---- R8, R7 saturation and drain
    do_reset();
    repeat (DMAX * REFI - 1) step();
    chk("R8 urgent early", urgent, 0);
    step();
    chk("R8 urgent at limit", urgent, 1);
    repeat (2 * REFI) step();
    chk("R8 urgent held", urgent, 1);
    nref = 0;
    for (int i = 0; i < 60; i++) begin
      gnt = req;
      step();
      gnt = 1'b0;
      if (vld && code() == 1) nref++;
    end
    chk("R8 saturated drain count", nref, DMAX);
    chk("R7 request clear after drain", req, 0);
    chk("R8 urgent clear after drain", urgent, 0);

    // ---- R9, R10
    do_reset();
    repeat (5) step();
    self_ref = 1'b1;
    step();
    chk("R9 self request", req, 1);
    grant();
    chk("R9 self code", vld ? code() : -1, 1);
    chk("R9 cke low", cke, 0);
    miss = 0;
    for (int i = 0; i < 150; i++) begin step(); if (cke || vld || !lockout || req) miss++; end
    chk("R9 self hold", miss, 0);
    self_ref = 1'b0;
    step();
    chk("R9 cke high", cke, 1);
    repeat (TRFC - 1) step();
    chk("R9 lockout after exit", lockout, 1);
    step();
    chk("R9 lockout off", lockout, 0);
    chk("R10 debt cleared", req, 0);
    repeat (REFI - 1 - TRFC) step();
    chk("R10 before tick", req, 0);
    step();
    chk("R10 tick after exit", req, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule